// File: doc/BRIEF.md
# Network Controller Register File

This block is the host-visible register file of a network controller. It holds sixteen 16-bit registers that a host reaches over a 32-bit slave bus through a word-index address port. Each register has a fixed write rule: some bits are read-only, the status register is write-one-to-clear, the error tallies store the inverse of what is written, the two data-configuration registers can only be written while the controller is held in soft reset, and the receive-resource pointers drop their low address bits according to the configured data width.

A big-endian input selects which half of the 32-bit bus carries the 16-bit register value, for both reads and writes. The status register also collects event pulses from the datapath. The block drives a level interrupt formed from the status and mask registers. It also drives a resource-fetch start pulse, which is raised either by the fetch command bit or by the host clearing the buffer-exhausted status bit. The fetch engine answers with a done pulse.

Register map (word index): 0 command, 1 data config, 2 data config 2, 3 transmit control, 4 receive control, 5 interrupt mask, 6 interrupt status, 7 resource start, 8 resource end, 9 resource read pointer, 10 resource write pointer, 11-13 error tallies, 14 revision, 15 scratch.

Top module: `nic_regfile`

## Requirements
- R1: With `big_endian` high, the register value is taken from and returned on bus bits 31:16 and bits 15:0 read as zero. With `big_endian` low, the value uses bits 15:0 and bits 31:16 read as zero.
- R2: After reset the command register reads 0x0085 (bit 7 soft reset, bit 2 stop, bit 0 receiver off), the revision register reads 0x0004, and every other register and the interrupt output read zero.
- R3: A write to data config stores the value AND 0xBFFF, and a write to data config 2 stores the value AND 0xF017, only while command bit 7 is set. Otherwise the write leaves them unchanged.
- R4: A write to transmit control stores the value AND 0xF000. A write to receive control stores the value AND 0xFFE0. A write to interrupt mask stores the value AND 0x7FFF.
- R5: A write to interrupt status clears every bit written as 1. An event pulse on `evt_set` sets its bits, and a set wins over a clear in the same cycle.
- R6: The four resource pointers store the value AND 0xFFFC when data config bit 5 (32-bit width) is set, and the value AND 0xFFFE otherwise.
- R7: The three error tallies store the bitwise inverse of the written value.
- R8: Writes to the revision register are ignored, and it keeps reading 0x0004.
- R9: `irq` is the OR of (status AND mask). It reflects a register change one clock after the edge that changed the register.
- R10: Clearing status bit 5 (buffer exhausted) while it is set raises `fetch_start` for one cycle. Writing 1 to that bit while it is clear starts nothing.
- R11: Writing command bit 5 requests a fetch and raises `fetch_start`. The bit reads 1, even across later command writes, until `fetch_done` ends that fetch, and then it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| big_endian | input | 1 | Selects the upper bus half for register data |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_set | input | 16 | Status bits to set this cycle |
| fetch_done | input | 1 | Fetch engine finished the fetch in progress |
| fetch_start | output | 1 | Start a resource fetch |
| irq | output | 1 | Interrupt level |

## Verification
A corrupted mask or inversion shows on the next read of that register, one cycle after the write. A lock-check error in the data-config registers shows as a value that changes while the reset bit is clear. A wrong pointer alignment appears only after the width bit changes, so both widths are swept. A stale interrupt or a lost fetch request shows at the ports within one or two cycles, as a wrong `irq` level, a missing or doubled `fetch_start`, or a command fetch bit that clears early or never clears.

// File: rtl/nic_reg_pkg.sv
package nic_reg_pkg;
  localparam int DW       = 16;
  localparam int BW       = 2 * DW;
  localparam int NREG     = 16;
  localparam int AW       = $clog2(NREG);

  localparam int IDX_CMD   = 0;
  localparam int IDX_DCFG  = 1;
  localparam int IDX_DCFG2 = 2;
  localparam int IDX_TXC   = 3;
  localparam int IDX_RXC   = 4;
  localparam int IDX_IMSK  = 5;
  localparam int IDX_ISTAT = 6;
  localparam int IDX_PTR0  = 7;
  localparam int NPTR      = 4;
  localparam int IDX_TALLY0 = 11;
  localparam int NTALLY    = 3;
  localparam int IDX_REV   = 14;
  localparam int IDX_SCR   = 15;

  localparam logic [DW-1:0] CMD_RESET_VAL = 16'h0085;
  localparam logic [DW-1:0] REV_VAL       = 16'h0004;
  localparam int CMD_SRST_BIT  = 7;
  localparam int CMD_FETCH_BIT = 5;
  localparam int DCFG_WIDE_BIT = 5;
  localparam int ST_EXHAUST_BIT = 5;

  localparam logic [DW-1:0] M_DCFG  = 16'hBFFF;
  localparam logic [DW-1:0] M_DCFG2 = 16'hF017;
  localparam logic [DW-1:0] M_TXC   = 16'hF000;
  localparam logic [DW-1:0] M_RXC   = 16'hFFE0;
  localparam logic [DW-1:0] M_IMSK  = 16'h7FFF;
  localparam logic [DW-1:0] M_WIDE  = 16'hFFFC;
  localparam logic [DW-1:0] M_NARROW = 16'hFFFE;

  typedef enum logic [2:0] {
    WR_PLAIN, WR_MASK, WR_LOCKED, WR_ALIGN, WR_INVERT, WR_NONE
  } wr_kind_e;
endpackage

// File: rtl/nic_reg_lane.sv
module nic_reg_lane
  import nic_reg_pkg::*;
(
  input  logic          big_endian,
  input  logic [BW-1:0] bus_wdata,
  input  logic [DW-1:0] rd_val,
  output logic [DW-1:0] wr_val,
  output logic [BW-1:0] bus_rdata
);
  always_comb begin
    if (big_endian) begin
      wr_val    = bus_wdata[BW-1:DW];
      bus_rdata = {rd_val, {DW{1'b0}}};
    end else begin
      wr_val    = bus_wdata[DW-1:0];
      bus_rdata = {{DW{1'b0}}, rd_val};
    end
  end
endmodule

// File: rtl/nic_reg_rules.sv
module nic_reg_rules
  import nic_reg_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] val,
  input  logic          srst_mode,
  input  logic          wide_mode,
  output logic [DW-1:0] stored,
  output logic          allow
);
  wr_kind_e        kind;
  logic [DW-1:0]   mask;

  always_comb begin
    kind = WR_PLAIN;
    mask = '1;
    if (addr == AW'(IDX_DCFG)) begin
      kind = WR_LOCKED; mask = M_DCFG;
    end else if (addr == AW'(IDX_DCFG2)) begin
      kind = WR_LOCKED; mask = M_DCFG2;
    end else if (addr == AW'(IDX_TXC)) begin
      kind = WR_MASK; mask = M_TXC;
    end else if (addr == AW'(IDX_RXC)) begin
      kind = WR_MASK; mask = M_RXC;
    end else if (addr == AW'(IDX_IMSK)) begin
      kind = WR_MASK; mask = M_IMSK;
    end else if (addr >= AW'(IDX_PTR0) && addr < AW'(IDX_PTR0 + NPTR)) begin
      kind = WR_ALIGN; mask = wide_mode ? M_WIDE : M_NARROW;
    end else if (addr >= AW'(IDX_TALLY0) && addr < AW'(IDX_TALLY0 + NTALLY)) begin
      kind = WR_INVERT;
    end else if (addr == AW'(IDX_REV)) begin
      kind = WR_NONE;
    end
  end

  always_comb begin
    unique case (kind)
      WR_INVERT: stored = ~val;
      WR_PLAIN:  stored = val;
      default:   stored = val & mask;
    endcase
    allow = (kind != WR_NONE) && ((kind != WR_LOCKED) || srst_mode);
  end
endmodule

// File: rtl/nic_reg_status.sv
module nic_reg_status
  import nic_reg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          w1c_en,
  input  logic [DW-1:0] w1c_val,
  input  logic [DW-1:0] evt_set,
  input  logic [DW-1:0] imask,
  output logic [DW-1:0] istat,
  output logic          exhaust_cleared,
  output logic          irq
);
  logic [DW-1:0] clr;
  assign clr = w1c_en ? (w1c_val & istat) : '0;
  assign exhaust_cleared = clr[ST_EXHAUST_BIT] & ~evt_set[ST_EXHAUST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      istat <= '0;
      irq   <= 1'b0;
    end else begin
      istat <= (istat & ~clr) | evt_set;
      irq   <= |(istat & imask);
    end
  end
endmodule

// File: rtl/nic_reg_fetch.sv
module nic_reg_fetch (
  input  logic clk,
  input  logic rst_n,
  input  logic req_cmd,
  input  logic req_stat,
  input  logic fetch_done,
  output logic fetch_start,
  output logic cmd_fetch_clr,
  output logic busy
);
  logic pend_cmd, pend_stat, src_cmd;

  assign fetch_start   = !busy && (pend_cmd || pend_stat);
  assign cmd_fetch_clr = busy && fetch_done && src_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_cmd  <= 1'b0;
      pend_stat <= 1'b0;
      busy      <= 1'b0;
      src_cmd   <= 1'b0;
    end else begin
      if (fetch_start) begin
        busy    <= 1'b1;
        src_cmd <= pend_cmd;
        if (pend_cmd) pend_cmd  <= 1'b0;
        else          pend_stat <= 1'b0;
      end else if (busy && fetch_done) begin
        busy <= 1'b0;
      end
      if (req_cmd)  pend_cmd  <= 1'b1;
      if (req_stat) pend_stat <= 1'b1;
    end
  end
endmodule

// File: rtl/nic_regfile.sv
module nic_regfile
  import nic_reg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          big_endian,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  input  logic [DW-1:0] evt_set,
  input  logic          fetch_done,
  output logic          fetch_start,
  output logic          irq
);
  logic [DW-1:0] rf [NREG];
  logic [DW-1:0] wr_val, stored, rd_val, istat;
  logic          allow, exhaust_cleared, cmd_fetch_clr, fetch_busy;
  logic          req_cmd, w1c_en;

  assign rd_val = rf[bus_addr];

  nic_reg_lane u_lane (
    .big_endian(big_endian), .bus_wdata(bus_wdata), .rd_val(rd_val),
    .wr_val(wr_val), .bus_rdata(bus_rdata)
  );

  nic_reg_rules u_rules (
    .addr(bus_addr), .val(wr_val),
    .srst_mode(rf[IDX_CMD][CMD_SRST_BIT]),
    .wide_mode(rf[IDX_DCFG][DCFG_WIDE_BIT]),
    .stored(stored), .allow(allow)
  );

  assign w1c_en = bus_we && (bus_addr == AW'(IDX_ISTAT));

  nic_reg_status u_status (
    .clk(clk), .rst_n(rst_n), .w1c_en(w1c_en), .w1c_val(wr_val),
    .evt_set(evt_set), .imask(rf[IDX_IMSK]), .istat(istat),
    .exhaust_cleared(exhaust_cleared), .irq(irq)
  );

  assign req_cmd = bus_we && (bus_addr == AW'(IDX_CMD)) &&
                   wr_val[CMD_FETCH_BIT] && !rf[IDX_CMD][CMD_FETCH_BIT];

  nic_reg_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .req_cmd(req_cmd), .req_stat(exhaust_cleared),
    .fetch_done(fetch_done), .fetch_start(fetch_start),
    .cmd_fetch_clr(cmd_fetch_clr), .busy(fetch_busy)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == IDX_ISTAT) begin : g_stat
      assign rf[i] = istat;
    end else if (i == IDX_REV) begin : g_rev
      assign rf[i] = REV_VAL;
    end else if (i == IDX_CMD) begin : g_cmd
      logic [DW-1:0] q, nxt;
      always_comb begin
        nxt = q;
        if (bus_we && bus_addr == AW'(i)) begin
          nxt = wr_val;
          nxt[CMD_FETCH_BIT] = wr_val[CMD_FETCH_BIT] | q[CMD_FETCH_BIT];
        end
        if (cmd_fetch_clr) nxt[CMD_FETCH_BIT] = 1'b0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CMD_RESET_VAL;
        else        q <= nxt;
      end
      assign rf[i] = q;
    end else begin : g_data
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   q <= '0;
        else if (bus_we && bus_addr == AW'(i) && allow) q <= stored;
      end
      assign rf[i] = q;
    end
  end
endmodule

// File: rtl/nic_regfile_checker.sv
module nic_regfile_checker
  import nic_reg_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          big_endian,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [BW-1:0] bus_rdata,
  input logic [DW-1:0] cmd_q,
  input logic [DW-1:0] dcfg_q,
  input logic [DW-1:0] ptr0_q,
  input logic [DW-1:0] istat,
  input logic [DW-1:0] imask,
  input logic          fetch_start,
  input logic          fetch_done,
  input logic          irq
);
  a_r3_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_q[CMD_SRST_BIT] |=> $stable(dcfg_q));

  a_r6_wide_align: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(IDX_PTR0) && dcfg_q[DCFG_WIDE_BIT]) |=> (ptr0_q[1:0] == 2'b00));

  a_r8_rev_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(IDX_REV) && !big_endian) |-> (bus_rdata == {{DW{1'b0}}, REV_VAL}));

  a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(istat & imask))));

  a_r10_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |=> !fetch_start);

  a_r11_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_q[CMD_FETCH_BIT]) |-> $past(fetch_done));
endmodule

bind nic_regfile nic_regfile_checker u_checker (
  .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .cmd_q(rf[nic_reg_pkg::IDX_CMD]), .dcfg_q(rf[nic_reg_pkg::IDX_DCFG]),
  .ptr0_q(rf[nic_reg_pkg::IDX_PTR0]), .istat(istat),
  .imask(rf[nic_reg_pkg::IDX_IMSK]), .fetch_start(fetch_start),
  .fetch_done(fetch_done), .irq(irq)
);

// File: tb/nic_regfile_bench.sv
module nic_regfile_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big_endian = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] evt_set = '0;
  logic        fetch_done = 1'b0;
  logic        fetch_start;
  logic        irq;

  int errors = 0;
  int checks = 0;
  int starts = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  nic_regfile u_nic_regfile (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_set(evt_set), .fetch_done(fetch_done), .fetch_start(fetch_start), .irq(irq)
  );

  always @(negedge clk) if (rst_n && fetch_start) starts++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] v);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = big_endian ? {v, 16'hDEAD} : {16'hBEEF, v};
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = big_endian ? bus_rdata[31:16] : bus_rdata[15:0];
  endtask

  task automatic expect_reg(input string req, input logic [3:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(req, {16'h0, v}, {16'h0, exp});
  endtask

  task automatic pulse_done();
    @(negedge clk); fetch_done = 1'b1;
    @(negedge clk); fetch_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    expect_reg("R2 cmd", 4'd0, 16'h0085);
    expect_reg("R2 rev", 4'd14, 16'h0004);
    for (int a = 1; a < 14; a++) expect_reg("R2 zero", 4'(a), 16'h0000);
    check("R2 irq", {31'h0, irq}, 32'h0);

    // R1 lanes
    big_endian = 1'b1;
    wr(4'd15, 16'hA5C3);
    #1 check("R1 big read", bus_rdata, 32'hA5C3_0000);
    big_endian = 1'b0;
    #1 check("R1 little read", bus_rdata, 32'h0000_A5C3);
    wr(4'd15, 16'h1234);
    #1 check("R1 little write", bus_rdata, 32'h0000_1234);

    // R3 config writes while in soft reset, then locked
    wr(4'd1, 16'hFFFF); expect_reg("R3 dcfg", 4'd1, 16'hBFFF);
    wr(4'd2, 16'hFFFF); expect_reg("R3 dcfg2", 4'd2, 16'hF017);
    wr(4'd0, 16'h0000);
    wr(4'd1, 16'h1234); expect_reg("R3 dcfg locked", 4'd1, 16'hBFFF);
    wr(4'd2, 16'h0000); expect_reg("R3 dcfg2 locked", 4'd2, 16'hF017);

    // R6 wide mode (dcfg bit5 set)
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 16; k++) begin
        logic [15:0] val = 16'h1 << k | 16'h3;
        wr(4'(7 + p), val);
        expect_reg("R6 wide", 4'(7 + p), val & 16'hFFFC);
      end
    wr(4'd0, 16'h0080);
    wr(4'd1, 16'h0000); expect_reg("R3 dcfg unlocked", 4'd1, 16'h0000);
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 16; k++) begin
        logic [15:0] val = 16'h1 << k | 16'h3;
        wr(4'(7 + p), val);
        expect_reg("R6 narrow", 4'(7 + p), val & 16'hFFFE);
      end
    wr(4'd0, 16'h0000);

    // R4 masks
    for (int k = 0; k <= 16; k++) begin
      logic [15:0] val = (k == 16) ? 16'hFFFF : 16'h1 << k;
      wr(4'd3, val); expect_reg("R4 txc", 4'd3, val & 16'hF000);
      wr(4'd4, val); expect_reg("R4 rxc", 4'd4, val & 16'hFFE0);
      wr(4'd5, val); expect_reg("R4 imsk", 4'd5, val & 16'h7FFF);
    end
    wr(4'd5, 16'h0000);

    // R7 tallies
    for (int t = 0; t < 3; t++)
      for (int k = 0; k < 16; k++) begin
        logic [15:0] val = 16'(k * 16'h1111 + t);
        wr(4'(11 + t), val);
        expect_reg("R7 tally", 4'(11 + t), ~val);
      end

    // R8 revision read-only
    wr(4'd14, 16'hFFFF); expect_reg("R8 rev", 4'd14, 16'h0004);
    wr(4'd14, 16'h0000); expect_reg("R8 rev", 4'd14, 16'h0004);

    // R5 status set and write-one-to-clear
    @(negedge clk); evt_set = 16'hF0D0;
    @(negedge clk); evt_set = 16'h0000;
    expect_reg("R5 set", 4'd6, 16'hF0D0);
    wr(4'd6, 16'h3C1C); expect_reg("R5 w1c", 4'd6, 16'hC0C0);
    @(negedge clk);
    bus_addr = 4'd6; bus_wdata = {16'h0, 16'h0040}; bus_we = 1'b1; evt_set = 16'h0040;
    @(negedge clk); bus_we = 1'b0; evt_set = 16'h0000;
    expect_reg("R5 set wins", 4'd6, 16'hC0C0);

    // R9 interrupt
    check("R9 irq off", {31'h0, irq}, 32'h0);
    wr(4'd5, 16'h8000);
    @(negedge clk);
    check("R9 msb masked", {31'h0, irq}, 32'h0);
    wr(4'd5, 16'h0080);
    check("R9 not yet", {31'h0, irq}, 32'h0);
    @(negedge clk);
    check("R9 asserted", {31'h0, irq}, 32'h1);
    wr(4'd6, 16'h0080);
    @(negedge clk);
    check("R9 cleared", {31'h0, irq}, 32'h0);

    // R10 fetch from exhausted clear
    s0 = starts;
    wr(4'd6, 16'h0020);
    repeat (3) @(negedge clk);
    check("R10 no fetch when clear", 32'(starts - s0), 32'd0);
    @(negedge clk); evt_set = 16'h0020;
    @(negedge clk); evt_set = 16'h0000;
    wr(4'd6, 16'h0020);
    repeat (3) @(negedge clk);
    check("R10 fetch started", 32'(starts - s0), 32'd1);
    expect_reg("R10 bit cleared", 4'd6, 16'hC040);
    expect_reg("R10 cmd untouched", 4'd0, 16'h0000);
    pulse_done();

    // R11 command fetch bit
    s0 = starts;
    wr(4'd0, 16'h0020);
    repeat (2) @(negedge clk);
    check("R11 fetch started", 32'(starts - s0), 32'd1);
    expect_reg("R11 bit held", 4'd0, 16'h0020);
    wr(4'd0, 16'h0004);
    expect_reg("R11 bit held over write", 4'd0, 16'h0024);
    pulse_done();
    expect_reg("R11 bit cleared", 4'd0, 16'h0004);
    repeat (2) @(negedge clk);
    check("R11 single fetch", 32'(starts - s0), 32'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule